// File: doc/BRIEF.md
# Program-Array Read Port with SECDED Correction

This block is the bus-side read path in front of a program memory array. A bus master asks for a byte, an aligned 16-bit word or a misaligned 16-bit word. The port reads one aligned 32-bit half-phrase and its 7 check bits from a synchronous array per fetch. It runs a single-error-correct, double-error-detect decode on every fetch and returns the requested bytes together with two error flags.

A misaligned word needs two fetches, one for each byte, so it finishes one cycle later than a byte or an aligned word. The error flags for that access merge both checks. Correction works only inside the half-phrase that was fetched. One flipped bit per half-phrase is repaired, and two flipped bits are reported as uncorrectable. The array sits outside the port and is reached through a plain synchronous read interface. Its contents are written by other logic.

Top module: `flash_ecc_rdport`

## Requirements
- R1: While `rstN` is low, and on the first cycle after release, `ready`, `errSingle`, `errDouble` and `arrRdEn` are 0 and `rdData` is 0.
- R2: A request with `size` 2'b00 or 2'b01 is a byte read. `rdData[7:0]` holds the byte at `addr` and `rdData[15:8]` is 0. The request is taken at clock edge A, `ready` is high for exactly one cycle after edge A+1, and `rdData` holds its value until the next completion.
- R3: A request with `size` 2'b10 is an aligned word read, and `addr[0]` is treated as 0. `rdData` is big-endian: the byte at the even address goes in `rdData[15:8]` and the next byte goes in `rdData[7:0]`. It has the same timing as R2.
- R4: A request with `size` 2'b11 is a misaligned word read. `rdData[15:8]` is the byte at `addr` and `rdData[7:0]` is the byte at `addr+1`, with the address wrapping modulo 2^ADDR_W. The two bytes come from two separate fetches, the second at half-phrase index `(addr+1)>>2`. `ready` is high one cycle later than in R2, after edge A+2.
- R5: Fetches are issued with `arrRdEn` high and `arrAddr = addr>>2` in the cycle of the request. The array returns `arrRdata = {check[6:0], data[31:0]}` in the next cycle. Byte offset 0 of a half-phrase is `data[31:24]` and offset 3 is `data[7:0]`.
- R6: Code word layout: data bits 0..31 fill, in order, the positions 1..38 that are not powers of two. `check[j]` (j=0..5) is the XOR of the data bits whose position has bit j set. `check[6]` makes the XOR of all 39 bits even. A clean word returns its data with both flags 0.
- R7: A fetch with exactly one flipped bit among its 39 bits returns corrected data and sets `errSingle=1`, `errDouble=0`. This holds even if the flipped bit lies outside the requested bytes.
- R8: A fetch with exactly two flipped bits returns the stored data unaltered and sets `errDouble=1`, `errSingle=0`.
- R9: For a misaligned read, `errSingle` and `errDouble` are each the OR of the corresponding results of both fetches.
- R10: The flags are valid with `ready`, hold after it, and read 0 in the cycle after the next request is taken.
- R11: A request raised while an access is in progress is ignored. It produces no fetch address change for that access and no extra `ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Read request, taken when the port is idle |
| size | input | 2 | 00/01 byte, 10 aligned word, 11 misaligned word |
| addr | input | ADDR_W | Byte address |
| ready | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Returned byte or word |
| errSingle | output | 1 | A corrected single-bit fault was seen |
| errDouble | output | 1 | An uncorrectable fault was seen |
| arrRdEn | output | 1 | Array read strobe |
| arrAddr | output | ADDR_W-2 | Half-phrase index |
| arrRdata | input | 39 | Check bits and data from the array, one cycle after the strobe |

## Verification
The bench flips single bits in data, check and overall-parity positions. It reads bytes that do not cover the flipped bit, so a decoder that corrected the wrong position, or ignored parity-only faults, would return bad data or drop `errSingle`. Double faults are read back raw, which catches a decoder that "repairs" a double fault by flipping a third bit. Misaligned reads that cross into a faulty neighbour, and one that wraps from the top address to zero, expose a port that fetched the wrong half-phrase or kept only the last fetch's flags. A request injected mid-access shows whether a port restarts or emits a spurious completion.

// File: rtl/flash_ecc_pkg.sv
package flash_ecc_pkg;

  localparam int DATA_W = 32;
  localparam int CHK_W  = 7;
  localparam int CODE_W = DATA_W + CHK_W;
  localparam int SYN_W  = CHK_W - 1;
  localparam int MAX_POS = DATA_W + SYN_W;

  localparam logic [1:0] SZ_WORD  = 2'b10;
  localparam logic [1:0] SZ_SPLIT = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } rdState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic       clrFlags;
    logic       holdHi;
    logic       finish;
    logic       finishSplit;
    logic       wordMode;
    logic [1:0] byteSel;
  } dpCtrl_t;

  // Hamming position of data bit idx: the idx-th non-power-of-two from 1 up
  function automatic int dataPos(input int idx);
    int cnt;
    int res;
    cnt = -1;
    res = 0;
    for (int p = 1; p < 64; p++) begin
      if ((p & (p - 1)) != 0) begin
        cnt++;
        if (cnt == idx && res == 0) res = p;
      end
    end
    return res;
  endfunction

  function automatic logic [7:0] pickByte(input logic [DATA_W-1:0] w,
                                          input logic [1:0] off);
    return w[DATA_W - 1 - 8 * int'(off) -: 8];
  endfunction

endpackage

// File: rtl/flash_secded_dec.sv
module flash_secded_dec
  import flash_ecc_pkg::*;
(
  input  logic [CODE_W-1:0] codeIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              singleErr,
  output logic              doubleErr
);

  logic [SYN_W-1:0] contrib [DATA_W];
  logic [SYN_W-1:0] syndrome;
  logic             parityOdd;
  logic [DATA_W-1:0] flipMask;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_bit
      localparam int POS = dataPos(gi);
      assign contrib[gi]  = codeIn[gi] ? SYN_W'(POS) : '0;
      assign flipMask[gi] = singleErr && (syndrome == SYN_W'(POS));
    end
  endgenerate

  always_comb begin
    syndrome = codeIn[DATA_W +: SYN_W];
    for (int i = 0; i < DATA_W; i++) syndrome ^= contrib[i];
  end

  assign parityOdd = ^codeIn;
  assign singleErr = parityOdd && (syndrome <= SYN_W'(MAX_POS));
  assign doubleErr = (!parityOdd && syndrome != '0) ||
                     (parityOdd && syndrome > SYN_W'(MAX_POS));
  assign dataOut   = codeIn[DATA_W-1:0] ^ flipMask;

endmodule

// File: rtl/flash_rd_ctrl.sv
module flash_rd_ctrl
  import flash_ecc_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  output logic              arrRdEn,
  output logic [IDX_W-1:0]  arrAddr,
  output logic              ready,
  output logic              busy,
  output dpCtrl_t           dpCtrl
);

  rdState_t          state, stateNext;
  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] addrNext;
  logic [1:0]        sizeQ;
  logic              accept;

  assign accept   = (state == ST_IDLE) && req;
  assign addrNext = addrQ + ADDR_W'(1);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    dpCtrl    = '0;
    arrRdEn   = 1'b0;
    arrAddr   = addr[ADDR_W-1:2];
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (req) begin
          arrRdEn         = 1'b1;
          dpCtrl.clrFlags = 1'b1;
          stateNext       = ST_FIRST;
        end
      end
      ST_FIRST: begin
        dpCtrl.wordMode = (sizeQ == SZ_WORD);
        dpCtrl.byteSel  = (sizeQ == SZ_WORD) ? {addrQ[1], 1'b0} : addrQ[1:0];
        if (sizeQ == SZ_SPLIT) begin
          dpCtrl.holdHi = 1'b1;
          arrRdEn       = 1'b1;
          arrAddr       = addrNext[ADDR_W-1:2];
          stateNext     = ST_SECOND;
        end else begin
          dpCtrl.finish = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      ST_SECOND: begin
        dpCtrl.byteSel     = addrNext[1:0];
        dpCtrl.finishSplit = 1'b1;
        stateNext          = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      addrQ <= '0;
      sizeQ <= '0;
      ready <= 1'b0;
    end else begin
      state <= stateNext;
      ready <= dpCtrl.finish | dpCtrl.finishSplit;
      if (accept) begin
        addrQ <= addr;
        sizeQ <= size;
      end
    end
  end

endmodule

// File: rtl/flash_rd_dp.sv
module flash_rd_dp
  import flash_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] arrRdata,
  input  dpCtrl_t           dpCtrl,
  output logic [15:0]       rdData,
  output logic              errSingle,
  output logic              errDouble
);

  logic [DATA_W-1:0] fixedWord;
  logic              decSingle;
  logic              decDouble;
  logic [7:0]        hiByteQ;
  logic              accSingleQ;
  logic              accDoubleQ;
  logic [7:0]        selByte;
  logic [7:0]        nextByte;

  flash_secded_dec u_dec (
    .codeIn    (arrRdata),
    .dataOut   (fixedWord),
    .singleErr (decSingle),
    .doubleErr (decDouble)
  );

  assign selByte  = pickByte(fixedWord, dpCtrl.byteSel);
  assign nextByte = pickByte(fixedWord, dpCtrl.byteSel | 2'b01);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData     <= '0;
      errSingle  <= 1'b0;
      errDouble  <= 1'b0;
      hiByteQ    <= '0;
      accSingleQ <= 1'b0;
      accDoubleQ <= 1'b0;
    end else begin
      if (dpCtrl.clrFlags) begin
        errSingle <= 1'b0;
        errDouble <= 1'b0;
      end
      if (dpCtrl.holdHi) begin
        hiByteQ    <= selByte;
        accSingleQ <= decSingle;
        accDoubleQ <= decDouble;
      end
      if (dpCtrl.finish) begin
        rdData    <= dpCtrl.wordMode ? {selByte, nextByte} : {8'h00, selByte};
        errSingle <= decSingle;
        errDouble <= decDouble;
      end
      if (dpCtrl.finishSplit) begin
        rdData    <= {hiByteQ, selByte};
        errSingle <= accSingleQ | decSingle;
        errDouble <= accDoubleQ | decDouble;
      end
    end
  end

endmodule

// File: rtl/flash_ecc_rdport.sv
module flash_ecc_rdport
  import flash_ecc_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  output logic              ready,
  output logic [15:0]       rdData,
  output logic              errSingle,
  output logic              errDouble,
  output logic              arrRdEn,
  output logic [IDX_W-1:0]  arrAddr,
  input  logic [CODE_W-1:0] arrRdata
);

  dpCtrl_t dpCtrl;
  logic    busy;

  flash_rd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .req     (req),
    .size    (size),
    .addr    (addr),
    .arrRdEn (arrRdEn),
    .arrAddr (arrAddr),
    .ready   (ready),
    .busy    (busy),
    .dpCtrl  (dpCtrl)
  );

  flash_rd_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .arrRdata  (arrRdata),
    .dpCtrl    (dpCtrl),
    .rdData    (rdData),
    .errSingle (errSingle),
    .errDouble (errDouble)
  );

endmodule

// File: rtl/flash_ecc_rdport_chk.sv
module flash_ecc_rdport_chk #(
  parameter int ADDR_W = 10,
  localparam int IDX_W = ADDR_W - 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              req,
  input logic [1:0]        size,
  input logic [ADDR_W-1:0] addr,
  input logic              busy,
  input logic              arrRdEn,
  input logic [IDX_W-1:0]  arrAddr,
  input logic              ready,
  input logic [15:0]       rdData,
  input logic              errSingle,
  input logic              errDouble
);

  logic              accept;
  logic [ADDR_W-1:0] addrPlus;

  assign accept   = req && !busy;
  assign addrPlus = addr + ADDR_W'(1);

  assert_fetch_on_accept_R5: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> (arrRdEn && arrAddr == addr[ADDR_W-1:2]));

  // covers R3 as well: same timing for aligned words
  assert_short_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    (accept && size != 2'b11) |=> ##1 ready);

  assert_split_latency_R4: assert property (@(posedge clk) disable iff (!rstN)
    (accept && size == 2'b11) |=> ##1 (!ready) ##1 ready);

  assert_second_fetch_R4: assert property (@(posedge clk) disable iff (!rstN)
    (accept && size == 2'b11) |=>
      (arrRdEn && arrAddr == IDX_W'($past(addrPlus) >> 2)));

  assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> !ready);

  assert_flags_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (!errSingle && !errDouble));

  assert_outputs_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(accept) && !ready) |->
      ($stable(errSingle) && $stable(errDouble) && $stable(rdData)));

endmodule

bind flash_ecc_rdport flash_ecc_rdport_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/flash_ecc_rdport_tb.sv
module flash_ecc_rdport_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 10;
  localparam int IDX_W = ADDR_W - 2;
  localparam int WORDS = 1 << IDX_W;

  typedef struct packed {
    logic [15:0] d;
    logic        s;
    logic        e;
  } exp_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              req = 1'b0;
  logic [1:0]        size = 2'b00;
  logic [ADDR_W-1:0] addr = '0;
  logic              ready;
  logic [15:0]       rdData;
  logic              errSingle;
  logic              errDouble;
  logic              arrRdEn;
  logic [IDX_W-1:0]  arrAddr;
  logic [38:0]       arrRdata = '0;

  logic [31:0] clean  [WORDS];
  logic [38:0] mask   [WORDS];
  logic [38:0] stored [WORDS];

  exp_t  expQ [$];
  int    dueQ [$];
  string tagQ [$];
  exp_t  lastExp;
  int    cyc = 0;
  int    nChk = 0;
  int    nBad = 0;
  bit    finished = 0;

  flash_ecc_rdport #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .req(req), .size(size), .addr(addr),
    .ready(ready), .rdData(rdData), .errSingle(errSingle), .errDouble(errDouble),
    .arrRdEn(arrRdEn), .arrAddr(arrAddr), .arrRdata(arrRdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (arrRdEn) arrRdata <= stored[arrAddr];

  function automatic logic [38:0] enc(input logic [31:0] d);
    logic [6:0] c;
    int k;
    c = '0;
    k = 0;
    for (int p = 1; p <= 38; p++) begin
      if ((p & (p - 1)) != 0) begin
        for (int j = 0; j < 6; j++) if (p[j]) c[j] ^= d[k];
        k++;
      end
    end
    c[6] = ^{d, c[5:0]};
    return {c, d};
  endfunction

  task automatic setMask(input int idx, input logic [38:0] m);
    mask[idx]   = m;
    stored[idx] = enc(clean[idx]) ^ m;
  endtask

  // byte at address with fault-model outcome of its half-phrase
  function automatic logic [7:0] byteAt(input logic [ADDR_W-1:0] a);
    int idx;
    logic [31:0] w;
    idx = int'(a >> 2);
    w = ($countones(mask[idx]) == 2) ? stored[idx][31:0] : clean[idx];
    return w[31 - 8 * int'(a[1:0]) -: 8];
  endfunction

  function automatic logic fltS(input logic [ADDR_W-1:0] a);
    return $countones(mask[int'(a >> 2)]) == 1;
  endfunction

  function automatic logic fltD(input logic [ADDR_W-1:0] a);
    return $countones(mask[int'(a >> 2)]) == 2;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exv);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exv);
    end
  endtask

  // driver: issue one read and push the expectation
  task automatic doRead(input logic [ADDR_W-1:0] a, input logic [1:0] sz,
                        input string tag, input bit intrude = 0);
    exp_t x;
    logic [ADDR_W-1:0] a0;
    logic [ADDR_W-1:0] a1;
    int lat;
    if (sz == 2'b11) begin
      a0 = a; a1 = a + ADDR_W'(1);
      x.d = {byteAt(a0), byteAt(a1)};
      x.s = fltS(a0) | fltS(a1);
      x.e = fltD(a0) | fltD(a1);
      lat = 2;
    end else if (sz == 2'b10) begin
      a0 = {a[ADDR_W-1:1], 1'b0};
      x.d = {byteAt(a0), byteAt(a0 | ADDR_W'(1))};
      x.s = fltS(a0); x.e = fltD(a0);
      lat = 1;
    end else begin
      x.d = {8'h00, byteAt(a)};
      x.s = fltS(a); x.e = fltD(a);
      lat = 1;
    end
    req = 1'b1; addr = a; size = sz;
    @(negedge clk);
    expQ.push_back(x);
    dueQ.push_back(cyc + lat);
    tagQ.push_back(tag);
    lastExp = x;
    check(!errSingle && !errDouble, "R10", "flags after accept",
          {30'd0, errSingle, errDouble}, 32'd0);
    if (intrude) begin
      req = 1'b1; addr = a ^ ADDR_W'(10'h155); size = 2'b00;
    end else begin
      req = 1'b0;
    end
    @(negedge clk);
    req = 1'b0;
    if (lat == 2) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pop and compare on every completion
  always @(negedge clk) begin
    if (rstN && !finished && ready) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R11", "unexpected ready", 32'd1, 32'd0);
      end else begin
        exp_t  x;
        int    due;
        string tg;
        x = expQ.pop_front(); due = dueQ.pop_front(); tg = tagQ.pop_front();
        check(rdData == x.d, tg, "rdData", {16'd0, rdData}, {16'd0, x.d});
        check(errSingle == x.s && errDouble == x.e, tg, "flags {single,double}",
              {30'd0, errSingle, errDouble}, {30'd0, x.s, x.e});
        check(cyc == due, tg, "ready cycle", cyc, due);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      clean[i] = (32'h9E3779B9 * (i + 1)) ^ 32'h5A00C3F0;
      setMask(i, '0);
    end
    idle(3);
    // R1: reset state
    check(!ready && !errSingle && !errDouble && !arrRdEn && rdData == 16'd0,
          "R1", "outputs in reset", {11'd0, ready, errSingle, errDouble, arrRdEn, rdData},
          32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!ready && !errSingle && !errDouble && !arrRdEn && rdData == 16'd0,
          "R1", "outputs after release", {11'd0, ready, errSingle, errDouble, arrRdEn, rdData},
          32'd0);

    // R5/R2/R6: byte lanes on clean data
    doRead(10'h010, 2'b00, "R5");
    doRead(10'h011, 2'b00, "R5");
    doRead(10'h012, 2'b00, "R5");
    doRead(10'h013, 2'b00, "R6");
    doRead(10'h025, 2'b01, "R2");
    // R3: aligned words, addr[0] ignored
    doRead(10'h040, 2'b10, "R3");
    doRead(10'h043, 2'b10, "R3");
    // R4: misaligned, inside, crossing, wrapping
    doRead(10'h051, 2'b11, "R4");
    doRead(10'h053, 2'b11, "R4");
    doRead(10'h3FF, 2'b11, "R4");

    // R7: single faults in data, check and overall parity bits
    setMask(8'h20, 39'h1 << 0);
    setMask(8'h21, 39'h1 << 31);
    setMask(8'h22, 39'h1 << 35);
    setMask(8'h23, 39'h1 << 38);
    setMask(8'h24, 39'h1 << 12);
    doRead(10'h083, 2'b00, "R7");
    doRead(10'h084, 2'b10, "R7");
    doRead(10'h088, 2'b00, "R7");
    doRead(10'h08C, 2'b00, "R7");
    doRead(10'h090, 2'b00, "R7");

    // R8: double faults returned raw
    setMask(8'h30, (39'h1 << 3) | (39'h1 << 20));
    setMask(8'h31, (39'h1 << 5) | (39'h1 << 34));
    doRead(10'h0C0, 2'b10, "R8");
    doRead(10'h0C7, 2'b00, "R8");

    // R9: misaligned reads merging both fetches
    setMask(8'h40, 39'h1 << 2);
    setMask(8'h41, (39'h1 << 1) | (39'h1 << 9));
    setMask(8'h43, 39'h1 << 30);
    doRead(10'h103, 2'b11, "R9");
    // R10: flags and data hold while idle
    idle(3);
    check(errSingle == lastExp.s && errDouble == lastExp.e && rdData == lastExp.d,
          "R10", "hold after ready", {15'd0, errSingle, rdData}, {15'd0, lastExp.s, lastExp.d});
    doRead(10'h107, 2'b11, "R9");
    doRead(10'h10B, 2'b11, "R9");

    // R11: request during an access is dropped
    doRead(10'h201, 2'b11, "R11", 1'b1);
    idle(4);
    doRead(10'h202, 2'b00, "R11");
    idle(4);

    check(expQ.size() == 0, "R11", "pending expectations", expQ.size(), 32'd0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule